// File: doc/BRIEF.md
# UART Receive Line-Status Tracker

This block keeps the receive half of a UART's line status byte. A receive shift register hands it one pulse per finished character, along with that character's data and its parity, framing and break flags. The block holds the character in one of two ways. In single-buffer mode it keeps one holding register. In queued mode it keeps a receive FIFO, and every entry there stores its own error flags.

The block builds the eight-bit status word from this state: data-ready, overrun, the three per-character error bits, and an aggregate "some queued character is bad" flag. The two transmitter-empty bits come in from the transmit side and are passed straight through.

A bus reads characters through the data-read strobe and reads the status word through the status-read strobe. There is no write path into the status word. When the queue-enable control changes value, the block flushes all receive state.

Top module: `uart_rx_status`

## Requirements
- R1: While `rst_ni` is low, and right after it is released with both transmitter inputs high, `stat_o` equals 8'h60. Bits 0 to 4 and bit 7 are 0, and bits 5 and 6 are 1. The reset is asynchronous.
- R2: Outside reset, `stat_o[5]` follows `thr_empty_i` and `stat_o[6]` follows `tx_idle_i`.
- R3: `stat_o[0]` (data ready) has two modes. In single-buffer mode it is 1 after a character loads and stays 1 until a `data_rd_i` with no new character in the same cycle. In queued mode it is 1 exactly while the FIFO holds at least one entry.
- R4: Single-buffer mode, overrun. A character that arrives while the held one is unread, and with no `data_rd_i` in the same cycle, sets `stat_o[1]` and replaces the held data.
- R5: Queued mode, overrun. A character that arrives while the FIFO holds `FIFO_DEPTH` entries sets `stat_o[1]` and is discarded. This holds even with a pop in the same cycle.
- R6: Single-buffer mode, error bits. `stat_o[2]` (parity), `stat_o[3]` (framing) and `stat_o[4]` (break) latch from the flags of arriving characters. A `stat_rd_i` clears them and `stat_o[1]`. A flag arriving in the same cycle as the read wins.
- R7: Queued mode, error bits. `stat_o[4:2]` show the flags stored with the head entry. A `stat_rd_i` clears the head entry's stored flags. `stat_o[1]` also clears on `stat_rd_i`.
- R8: `stat_o[7]` sets when a flagged entry is in the FIFO. It stays set until a `stat_rd_i` at which no flagged entry remains. In single-buffer mode it is always 0.
- R9: In a cycle where `fifo_en_i` differs from the current mode, the mode switches at the edge. All receive state is flushed (`stat_o[4:0]` and `stat_o[7]` read 0), and any character arriving in that cycle is dropped.
- R10: Queued mode. Characters leave on `rx_data_o` in arrival order. A push and a pop may take place in the same cycle.
- R11: Single-buffer mode. `rx_data_o` shows the last character loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle pulse: a character has finished in the shift register |
| rx_data_i | input | DATA_W | Finished character |
| rx_par_err_i | input | 1 | Parity flag of the finished character |
| rx_frm_err_i | input | 1 | Framing flag of the finished character |
| rx_brk_i | input | 1 | Break flag of the finished character |
| fifo_en_i | input | 1 | 1 selects queued mode, 0 selects single-buffer mode |
| data_rd_i | input | 1 | Bus read of the receive data port |
| stat_rd_i | input | 1 | Bus read of the status word |
| thr_empty_i | input | 1 | Transmit holding register empty, from the transmitter |
| tx_idle_i | input | 1 | Transmitter fully empty, from the transmitter |
| stat_o | output | 8 | Line status word |
| rx_data_o | output | DATA_W | Held character, or the FIFO head character |

## Verification
The bench builds the block with `FIFO_DEPTH=4` and `DATA_W=8`. With that depth, full-queue overrun, the drop of the incoming character, and wrap of the pointers all come up within a few cycles of each sweep. A patterned sweep covers every combination of arrival, the three flags, data read and status read in both modes. Mode switches are made with the FIFO both empty and loaded, so a flush is seen wiping out pending head flags and the aggregate error bit.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_OE   = 1;
  localparam int unsigned LSR_PE   = 2;
  localparam int unsigned LSR_FE   = 3;
  localparam int unsigned LSR_BI   = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LSR_FERR = 7;
endpackage

// File: rtl/uart_lsr_hold.sv
module uart_lsr_hold
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  rx_err_t           werr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              oe_o,
  output rx_err_t           err_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, oe_q;
  rx_err_t           err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
      err_q  <= '0;
    end else if (flush_i) begin
      full_q <= 1'b0;
      oe_q   <= 1'b0;
      err_q  <= '0;
    end else begin
      if (load_i) data_q <= wdata_i;
      full_q <= load_i | (full_q & ~rd_data_i);
      // new event wins over a same-cycle status read
      oe_q   <= (oe_q & ~rd_stat_i) | (load_i & full_q & ~rd_data_i);
      err_q  <= (err_q & {3{~rd_stat_i}}) | (load_i ? werr_i : '0);
    end
  end

  assign rdata_o = data_q;
  assign full_o  = full_q;
  assign oe_o    = oe_q;
  assign err_o   = err_q;

  AST_HOLD_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && full_q && !rd_data_i && !flush_i) |=> oe_q); // R4
  AST_STAT_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !load_i) |=> (err_q == '0 && !oe_q)); // R6
endmodule

// File: rtl/uart_lsr_fifo.sv
module uart_lsr_fifo
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              clr_head_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  rx_err_t           werr_i,
  output logic [DATA_W-1:0] rdata_o,
  output rx_err_t           rerr_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              err_any_nxt_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  rx_err_t           err_q [DEPTH];
  rx_err_t           err_d [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < int'(DEPTH); i++) err_d[i] = err_q[i];
    if (clr_head_i && !empty_o) err_d[rptr_q] = '0;
    if (do_pop) begin
      vld_d[rptr_q] = 1'b0;
      err_d[rptr_q] = '0;
    end
    if (do_push) begin
      vld_d[wptr_q] = 1'b1;
      err_d[wptr_q] = werr_i;
    end
    if (flush_i) begin
      vld_d = '0;
      for (int i = 0; i < int'(DEPTH); i++) err_d[i] = '0;
    end
  end

  always_comb begin
    err_any_nxt_o = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++)
      err_any_nxt_o = err_any_nxt_o | (vld_d[i] & (|err_d[i]));
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
        err_q[g] <= '0;
      end else begin
        if (do_push && !flush_i && wptr_q == AW'(g)) mem_q[g] <= wdata_i;
        err_q[g] <= err_d[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      vld_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign rerr_o  = vld_q[rptr_q] ? err_q[rptr_q] : '0;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R5
  AST_LAST_POP_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !do_push && cnt_q == CW'(1) && !flush_i) |=> empty_o); // R3
  AST_HEAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> vld_q[rptr_q]); // R10
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              rx_brk_i,
  input  logic              fifo_en_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  input  logic              thr_empty_i,
  input  logic              tx_idle_i,
  output logic [7:0]        stat_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic    mode_q, toggle;
  logic    oe_q, ferr_q;
  rx_err_t in_err;

  logic [DATA_W-1:0] hold_data, fifo_data;
  logic              hold_full, hold_oe;
  rx_err_t           hold_err, head_err;
  logic              fifo_empty, fifo_full, fifo_err_nxt;

  assign in_err = '{brk: rx_brk_i, frm: rx_frm_err_i, par: rx_par_err_i};
  assign toggle = fifo_en_i ^ mode_q;

  uart_lsr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (toggle),
    .load_i    (rx_valid_i & ~mode_q),
    .rd_data_i (data_rd_i & ~mode_q),
    .rd_stat_i (stat_rd_i & ~mode_q),
    .wdata_i   (rx_data_i),
    .werr_i    (in_err),
    .rdata_o   (hold_data),
    .full_o    (hold_full),
    .oe_o      (hold_oe),
    .err_o     (hold_err)
  );

  uart_lsr_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (toggle),
    .push_i        (rx_valid_i & mode_q),
    .pop_i         (data_rd_i & mode_q),
    .clr_head_i    (stat_rd_i & mode_q),
    .wdata_i       (rx_data_i),
    .werr_i        (in_err),
    .rdata_o       (fifo_data),
    .rerr_o        (head_err),
    .empty_o       (fifo_empty),
    .full_o        (fifo_full),
    .err_any_nxt_o (fifo_err_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      oe_q   <= 1'b0;
      ferr_q <= 1'b0;
    end else if (toggle) begin
      mode_q <= fifo_en_i;
      oe_q   <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      // queued-mode overrun: full FIFO drops the byte, even with a pop
      oe_q   <= (oe_q & ~stat_rd_i) | (mode_q & rx_valid_i & fifo_full);
      // sticky until a status read finds no flagged entry left
      ferr_q <= (ferr_q & ~stat_rd_i) | fifo_err_nxt;
    end
  end

  rx_err_t shown_err;
  assign shown_err = mode_q ? head_err : hold_err;

  always_comb begin
    stat_o           = '0;
    stat_o[LSR_DR]   = mode_q ? ~fifo_empty : hold_full;
    stat_o[LSR_OE]   = mode_q ? oe_q : hold_oe;
    stat_o[LSR_PE]   = shown_err.par;
    stat_o[LSR_FE]   = shown_err.frm;
    stat_o[LSR_BI]   = shown_err.brk;
    stat_o[LSR_THRE] = thr_empty_i | ~rst_ni;
    stat_o[LSR_TEMT] = tx_idle_i | ~rst_ni;
    stat_o[LSR_FERR] = ferr_q;
  end

  assign rx_data_o = mode_q ? fifo_data : hold_data;

  AST_TOGGLE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle |=> (stat_o[4:0] == 5'b0 && !stat_o[LSR_FERR])); // R9
  AST_FIFO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !toggle && rx_valid_i && fifo_full) |=> stat_o[LSR_OE]); // R5
  AST_HOLD_NO_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !stat_o[LSR_FERR]); // R8
  AST_EMPTY_NO_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && fifo_empty) |-> !stat_o[LSR_DR]); // R3
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       par = 1'b0, frm = 1'b0, brk = 1'b0;
  logic       fifo_en = 1'b0;
  logic       data_rd = 1'b0, stat_rd = 1'b0;
  logic       thr_e = 1'b0, tx_i = 1'b0;
  logic [7:0] stat;
  logic [7:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_status #(.DATA_W(8), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .rx_par_err_i (par),
    .rx_frm_err_i (frm),
    .rx_brk_i     (brk),
    .fifo_en_i    (fifo_en),
    .data_rd_i    (data_rd),
    .stat_rd_i    (stat_rd),
    .thr_empty_i  (thr_e),
    .tx_idle_i    (tx_i),
    .stat_o       (stat),
    .rx_data_o    (rdata)
  );

  // reference state
  bit         m_mode = 0;
  bit         m_hf = 0, m_oe = 0, m_ferr = 0;
  logic [2:0] m_herr = '0;
  logic [7:0] m_hd = '0;
  logic [10:0] m_q[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit v, input logic [7:0] d, input logic [2:0] f,
                       input bit rr, input bit sr, input bit fe);
    if (fe != m_mode) begin
      m_mode = fe; m_hf = 0; m_oe = 0; m_herr = '0; m_ferr = 0;
      m_q.delete();
    end else if (!m_mode) begin
      m_oe   = (m_oe & !sr) | (v & m_hf & !rr);
      m_herr = (m_herr & {3{!sr}}) | (v ? f : 3'b0);
      if (v) m_hd = d;
      m_hf = v | (m_hf & !rr);
    end else begin
      int  n0 = m_q.size();
      bit  any = 0;
      m_oe = (m_oe & !sr) | (v && n0 == int'(DEPTH));
      if (sr && n0 > 0) m_q[0][10:8] = 3'b000;
      if (rr && n0 > 0) void'(m_q.pop_front());
      if (v && n0 < int'(DEPTH)) m_q.push_back({f, d});
      foreach (m_q[i]) any |= |m_q[i][10:8];
      m_ferr = (m_ferr & !sr) | any;
    end
  endtask

  task automatic compare(input bit was_toggle);
    bit         dr;
    logic [2:0] e;
    logic [7:0] dexp;
    string      t_dr, t_oe, t_er, t_fe, t_dt;
    dr   = m_mode ? (m_q.size() > 0) : m_hf;
    e    = m_mode ? ((m_q.size() > 0) ? m_q[0][10:8] : 3'b000) : m_herr;
    dexp = m_mode ? ((m_q.size() > 0) ? m_q[0][7:0] : 8'h00) : m_hd;
    t_dr = "R3 data ready";
    t_oe = m_mode ? "R5 fifo overrun" : "R4 hold overrun";
    t_er = m_mode ? "R7 head errors" : "R6 latched errors";
    t_fe = "R8 fifo error";
    t_dt = m_mode ? "R10 fifo data" : "R11 hold data";
    if (was_toggle) begin
      t_dr = "R9 flush dr"; t_oe = "R9 flush oe"; t_er = "R9 flush errs"; t_fe = "R9 flush ferr";
    end
    chk(t_dr, {7'b0, stat[0]}, {7'b0, dr});
    chk(t_oe, {7'b0, stat[1]}, {7'b0, m_oe});
    chk(t_er, {5'b0, stat[4:2]}, {5'b0, e});
    chk(t_fe, {7'b0, stat[7]}, {7'b0, (m_mode ? m_ferr : 1'b0)});
    chk("R2 tx bits", {6'b0, stat[6:5]}, {6'b0, tx_i, thr_e});
    if (dr) chk(t_dt, rdata, dexp);
  endtask

  task automatic step(input bit v, input logic [7:0] d, input logic [2:0] f,
                      input bit rr, input bit sr, input bit fe);
    bit tg;
    tg = (fe != m_mode);
    rx_valid = v; rx_data = d; par = f[0]; frm = f[1]; brk = f[2];
    data_rd = rr; stat_rd = sr; fifo_en = fe;
    model(v, d, f, rr, sr, fe);
    @(posedge clk);
    #1;
    rx_valid = 0; data_rd = 0; stat_rd = 0;
    compare(tg);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset value, with transmitter inputs held low during reset
    #(CLK_PERIOD * 2 + 2);
    chk("R1 reset value", stat, 8'h60);
    thr_e = 1; tx_i = 1;
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", stat, 8'h60);

    // R2 pass-through sweep
    for (int i = 0; i < 4; i++) begin
      thr_e = i[0]; tx_i = i[1];
      #1;
      chk("R2 tx bits", {6'b0, stat[6:5]}, {6'b0, i[1:0]});
    end
    thr_e = 1; tx_i = 1;

    // hold mode directed: R4 overrun replaces data, R6 read clears
    step(1, 8'hA1, 3'b000, 0, 0, 0);
    step(1, 8'hB2, 3'b001, 0, 0, 0);
    chk("R4 replaced data", rdata, 8'hB2);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk("R6 cleared by read", {3'b0, stat[4:0]}, 8'h01);
    step(1, 8'hC3, 3'b110, 0, 1, 0);
    chk("R6 arrival wins", {5'b0, stat[4:2]}, 8'h06);

    // hold mode sweep over arrival, flags, data read, status read
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      p = 8'((i * 53 + 11) & 255);
      step(p[0] | p[1], 8'(i), p[4:2], p[5], p[6], 0);
    end

    // R9 switch to queued mode with a byte arriving: dropped
    step(1, 8'h5A, 3'b111, 0, 0, 1);
    chk("R9 flushed", {stat[7], 2'b0, stat[4:0]}, 8'h00);

    // R5 fill past depth
    for (int i = 0; i < int'(DEPTH) + 2; i++) step(1, 8'(8'h10 + i), 3'(i % 3 == 1 ? 1 : 0), 0, 0, 1);
    chk("R5 overrun bit", {7'b0, stat[1]}, 8'h01);
    // R7 head flag, R10 order
    for (int i = 0; i < int'(DEPTH); i++) begin
      chk("R10 order", rdata, 8'(8'h10 + i));
      step(0, 8'h00, 3'b000, 1, 0, 1);
    end
    chk("R8 sticky without status read", {7'b0, stat[7]}, 8'h01);
    step(0, 8'h00, 3'b000, 0, 1, 1);
    chk("R8 cleared when none remain", {7'b0, stat[7]}, 8'h00);

    // queued mode sweep: filling phase then draining phase
    for (int i = 0; i < 512; i++) begin
      logic [7:0] p;
      bit rr;
      p  = 8'((i * 53 + 7) & 255);
      rr = (i < 256) ? (p[2] & p[3]) : (p[2] | p[3]);
      step(p[0] | p[1], 8'(i + 3), p[7:5], rr, p[4], 1);
    end

    // R9 toggle back with loaded FIFO and pending errors
    for (int i = 0; i < int'(DEPTH); i++) step(1, 8'(i), 3'b101, 0, 0, 1);
    step(0, 8'h00, 3'b000, 0, 0, 0);
    chk("R9 flush loaded", {stat[7], 2'b0, stat[4:0]}, 8'h00);
    step(1, 8'h77, 3'b000, 0, 0, 0);
    chk("R11 hold after switch", rdata, 8'h77);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] p;
      p = 8'((i * 29 + 5) & 255);
      step(p[0], 8'(i), p[3:1], p[4], p[5], p[6] & p[7]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule